// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Per-Port Write Behaviour

This block is a word-addressed memory with two access ports, A and B, that share one clock. Each port carries an enable, a write enable, an address and write data, and returns read data from an output register that loads only on a rising clock edge. No read path runs from an address straight to an output.

When a port writes, its output register does one of three things, and a parameter chooses which for each port on its own. It can take the word that was stored at the address before the write. It can take the incoming write data. It can keep the value it already holds.

A second parameter picks the port arrangement. In the full arrangement, each port may read or write in any combination on any cycle. In the split arrangement, port A only writes and port B only reads, and each uses its own address. The word width and the address width are parameters. The array and both output registers clear when the active-low reset is applied. The reset is applied at once and is released in step with the clock.

Top module: `dual_port_ram`

## Requirements
- R1: On a cycle where a port has enable 1 and write enable 0, its output register loads the word stored at its address. That value shows on the output after the next rising edge. Changing the address between edges does not change the output.
- R2: On a cycle where a port has enable 0, that port neither reads nor writes. Its output keeps its value, and the array is left unchanged even if write enable is 1.
- R3: A port set to the old-data mode (mode code 0) that writes stores its data. Its output then shows the word held at that address before the write.
- R4: A port set to the new-data mode (mode code 1) that writes stores its data. Its output then shows the data it wrote.
- R5: A port set to the hold mode (mode code 2) that writes stores its data. Its output keeps its previous value, so in this mode the output changes only on enabled reads.
- R6: In the full arrangement, both ports may read or write in the same cycle. A port that reads an address the other port writes in that cycle gets the contents from before the write.
- R7: When both ports write the same address in the same cycle, the array keeps port A's data.
- R8: While reset is low, both outputs are zero. After reset, every address reads as zero until it is written.
- R9: In the split arrangement, port A writes whenever it is enabled with write enable 1, and its output stays zero. Port B never writes, even with write enable 1, and it returns the stored word on every enabled read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge active |
| rst_n | input | 1 | Active-low reset, applied at once, released in step with the clock |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The cases that are hardest to reach from the ports are the ones where both ports point at the same word in the same cycle. These are a write on one port during a read on the other, and a write on both ports at once. Random addresses almost never meet these cases by chance, so the stimulus table builds them on purpose. A random phase then forces the two addresses to match on about a quarter of its cycles. A later read of each collided word shows which port's data was kept. Three copies of the block run side by side on the same stimulus, so that every write mode and both port arrangements see the same collisions.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // Output behaviour of a port on a cycle where it writes
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,  // output shows the word stored before the write
    WM_WRITE_FIRST = 2'd1,  // output shows the data just written
    WM_NO_CHANGE   = 2'd2   // output keeps its previous value
  } wmode_e;
endpackage

// File: rtl/dpram_rst_sync.sv
module dpram_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage0_q, stage0_d;
  logic stage1_q, stage1_d;

  always_comb begin
    stage0_d = 1'b1;
    stage1_d = stage0_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= stage0_d;
      stage1_q <= stage1_d;
    end
  end

  assign rst_n_o = stage1_q;
endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] wdata_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdata_b,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic              hit_a, hit_b, word_ce;
    logic [DATA_W-1:0] word_d;

    // Port A is selected last, so it wins a same-word collision
    always_comb begin
      hit_a   = wr_a && (addr_a == ADDR_W'(w));
      hit_b   = wr_b && (addr_b == ADDR_W'(w));
      word_ce = hit_a || hit_b;
      word_d  = hit_a ? wdata_a : wdata_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[w] <= '0;
      else if (word_ce) mem[w] <= word_d;
    end
  end

  // Pre-edge contents at each port's address
  assign word_a = mem[addr_a];
  assign word_b = mem[addr_b];

  property p_a_wins;
    @(posedge clk) disable iff (!rst_n)
      (wr_a && wr_b && (addr_a == addr_b)) |=> (mem[$past(addr_a)] == $past(wdata_a));
  endproperty
  assert_a_wins_collision_R7: assert property (p_a_wins);

  property p_write_lands;
    @(posedge clk) disable iff (!rst_n)
      (wr_b && !(wr_a && (addr_a == addr_b))) |=> (mem[$past(addr_b)] == $past(wdata_b));
  endproperty
  assert_b_write_lands_R6: assert property (p_write_lands);
endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
  import dpram_pkg::*;
#(
  parameter int     DATA_W = 8,
  parameter wmode_e MODE   = WM_READ_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [DATA_W-1:0] stored,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              load;
  logic [DATA_W-1:0] rdata_d;

  if (MODE == WM_WRITE_FIRST) begin : g_wf
    always_comb begin
      load    = en;
      rdata_d = we ? wdata : stored;
    end
  end else if (MODE == WM_NO_CHANGE) begin : g_nc
    always_comb begin
      load    = en && !we;
      rdata_d = stored;
    end
  end else begin : g_rf
    always_comb begin
      load    = en;
      rdata_d = stored;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (load) rdata <= rdata_d;
  end

  property p_idle_hold;
    @(posedge clk) disable iff (!rst_n) !en |=> $stable(rdata);
  endproperty
  assert_idle_holds_R2: assert property (p_idle_hold);

  property p_read;
    @(posedge clk) disable iff (!rst_n) (en && !we) |=> (rdata == $past(stored));
  endproperty
  assert_read_registered_R1: assert property (p_read);

  if (MODE == WM_WRITE_FIRST) begin : g_chk_wf
    property p_wf;
      @(posedge clk) disable iff (!rst_n) (en && we) |=> (rdata == $past(wdata));
    endproperty
    assert_write_first_R4: assert property (p_wf);
  end else if (MODE == WM_NO_CHANGE) begin : g_chk_nc
    property p_nc;
      @(posedge clk) disable iff (!rst_n) (en && we) |=> $stable(rdata);
    endproperty
    assert_no_change_R5: assert property (p_nc);
  end else begin : g_chk_rf
    property p_rf;
      @(posedge clk) disable iff (!rst_n) (en && we) |=> (rdata == $past(stored));
    endproperty
    assert_read_first_R3: assert property (p_rf);
  end
endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dpram_pkg::*;
#(
  parameter int     DATA_W    = 8,
  parameter int     ADDR_W    = 6,
  parameter wmode_e MODE_A    = WM_READ_FIRST,
  parameter wmode_e MODE_B    = WM_WRITE_FIRST,
  parameter bit     SIMPLE_DP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic              rst_n_s;
  logic              wr_a, wr_b;
  logic [DATA_W-1:0] word_a, word_b;

  dpram_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  dpram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_a    (wr_a),
    .addr_a  (a_addr),
    .wdata_a (a_wdata),
    .wr_b    (wr_b),
    .addr_b  (b_addr),
    .wdata_b (b_wdata),
    .word_a  (word_a),
    .word_b  (word_b)
  );

  if (SIMPLE_DP) begin : g_sdp
    // Port A writes only; port B reads only
    always_comb begin
      wr_a = a_en && a_we;
      wr_b = 1'b0;
    end
    assign a_rdata = '0;

    dpram_port_out #(.DATA_W(DATA_W), .MODE(MODE_B)) u_out_b (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .en     (b_en),
      .we     (1'b0),
      .stored (word_b),
      .wdata  (b_wdata),
      .rdata  (b_rdata)
    );
  end else begin : g_tdp
    always_comb begin
      wr_a = a_en && a_we;
      wr_b = b_en && b_we;
    end

    dpram_port_out #(.DATA_W(DATA_W), .MODE(MODE_A)) u_out_a (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .en     (a_en),
      .we     (a_we),
      .stored (word_a),
      .wdata  (a_wdata),
      .rdata  (a_rdata)
    );

    dpram_port_out #(.DATA_W(DATA_W), .MODE(MODE_B)) u_out_b (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .en     (b_en),
      .we     (b_we),
      .stored (word_b),
      .wdata  (b_wdata),
      .rdata  (b_rdata)
    );
  end
endmodule

// File: tb/test_dual_port_ram.sv
`timescale 1ns/1ps
module test_dual_port_ram;
  import dpram_pkg::*;

  localparam int DW = 8;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 14;

  // {a_en, a_we, a_addr[5:0], a_wdata[7:0], b_en, b_we, b_addr[5:0], b_wdata[7:0]}
  localparam logic [31:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 6'd0,  8'h00, 1'b1, 1'b0, 6'd63, 8'h00},  // reads after reset
    {1'b1, 1'b1, 6'd5,  8'hA5, 1'b1, 1'b0, 6'd5,  8'h00},  // A writes, B reads same word
    {1'b1, 1'b0, 6'd5,  8'h00, 1'b1, 1'b1, 6'd9,  8'h3C},
    {1'b1, 1'b1, 6'd12, 8'h11, 1'b1, 1'b1, 6'd12, 8'h22},  // double write same word
    {1'b1, 1'b0, 6'd12, 8'h00, 1'b1, 1'b0, 6'd12, 8'h00},  // readback: A wins
    {1'b1, 1'b1, 6'd5,  8'h5A, 1'b0, 1'b0, 6'd5,  8'h00},
    {1'b0, 1'b0, 6'd5,  8'h00, 1'b1, 1'b0, 6'd9,  8'h00},
    {1'b1, 1'b0, 6'd5,  8'h00, 1'b1, 1'b1, 6'd5,  8'h77},  // B writes, A reads same word
    {1'b1, 1'b0, 6'd5,  8'h00, 1'b1, 1'b0, 6'd5,  8'h00},
    {1'b1, 1'b1, 6'd63, 8'hFF, 1'b1, 1'b1, 6'd0,  8'h01},
    {1'b1, 1'b0, 6'd0,  8'h00, 1'b1, 1'b0, 6'd63, 8'h00},
    {1'b0, 1'b1, 6'd20, 8'hEE, 1'b1, 1'b0, 6'd20, 8'h00},  // disabled write ignored
    {1'b1, 1'b1, 6'd20, 8'hC3, 1'b1, 1'b1, 6'd20, 8'h3C},
    {1'b1, 1'b0, 6'd20, 8'h00, 1'b1, 1'b0, 6'd20, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic [DW-1:0] r1a, r1b, r2a, r2b, r3a, r3b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m1 [DEPTH];
  logic [DW-1:0] m2 [DEPTH];
  logic [DW-1:0] m3 [DEPTH];
  logic [DW-1:0] e1a, e1b, e2a, e2b, e3b;

  always #2.5 clk = ~clk;

  // Full arrangement: A old-data, B new-data
  dual_port_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_READ_FIRST),
                  .MODE_B(WM_WRITE_FIRST), .SIMPLE_DP(1'b0)) i_dual_port_ram (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(r1a),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(r1b));

  // Full arrangement: A hold, B old-data
  dual_port_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_NO_CHANGE),
                  .MODE_B(WM_READ_FIRST), .SIMPLE_DP(1'b0)) i_dual_port_ram_nc (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(r2a),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(r2b));

  // Split arrangement
  dual_port_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE_A(WM_READ_FIRST),
                  .MODE_B(WM_READ_FIRST), .SIMPLE_DP(1'b1)) i_dual_port_ram_sdp (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(r3a),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(r3b));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] nxt(input int mode, input logic en, input logic we,
      input logic [DW-1:0] old, input logic [DW-1:0] wd, input logic [DW-1:0] cur);
    if (!en) return cur;
    if (!we) return old;
    case (mode)
      0:       return old;
      1:       return wd;
      default: return cur;
    endcase
  endfunction

  function automatic string tag(input int mode, input logic en, input logic we,
                                input logic other_hits);
    if (!en) return "R2";
    if (we) begin
      if (mode == 0) return "R3";
      if (mode == 1) return "R4";
      return "R5";
    end
    if (other_hits) return "R6";
    return "R1";
  endfunction

  task automatic clear_models();
    for (int i = 0; i < DEPTH; i++) begin
      m1[i] = '0; m2[i] = '0; m3[i] = '0;
    end
    e1a = '0; e1b = '0; e2a = '0; e2b = '0; e3b = '0;
  endtask

  // Called just after a falling edge; checks outputs after the next rising edge
  task automatic step(input logic aen, input logic awe, input logic [AW-1:0] aa,
                      input logic [DW-1:0] awd, input logic ben, input logic bwe,
                      input logic [AW-1:0] ba, input logic [DW-1:0] bwd);
    string ta1, tb1, ta2, tb2;
    logic  b_hits_a, a_hits_b;
    a_en = aen; a_we = awe; a_addr = aa; a_wdata = awd;
    b_en = ben; b_we = bwe; b_addr = ba; b_wdata = bwd;
    #1;
    // R1: no path from address to output between edges
    chk("R1 output unchanged before edge", r1a, e1a);
    b_hits_a = ben && bwe && (ba == aa);
    a_hits_b = aen && awe && (ba == aa);
    ta1 = tag(0, aen, awe, b_hits_a); tb1 = tag(1, ben, bwe, a_hits_b);
    ta2 = tag(2, aen, awe, b_hits_a); tb2 = tag(0, ben, bwe, a_hits_b);
    e1a = nxt(0, aen, awe, m1[aa], awd, e1a);
    e1b = nxt(1, ben, bwe, m1[ba], bwd, e1b);
    e2a = nxt(2, aen, awe, m2[aa], awd, e2a);
    e2b = nxt(0, ben, bwe, m2[ba], bwd, e2b);
    e3b = nxt(0, ben, 1'b0, m3[ba], bwd, e3b);
    if (ben && bwe) begin m1[ba] = bwd; m2[ba] = bwd; end
    if (aen && awe) begin m1[aa] = awd; m2[aa] = awd; m3[aa] = awd; end
    @(posedge clk);
    @(negedge clk);
    chk({ta1, " port A old-data"}, r1a, e1a);
    chk({tb1, " port B new-data"}, r1b, e1b);
    chk({ta2, " port A hold"},     r2a, e2a);
    chk({tb2, " port B old-data"}, r2b, e2b);
    chk("R9 split port A output zero",  r3a, '0);
    chk("R9 split port B read only",    r3b, e3b);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    clear_models();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs zero in reset
    chk("R8 reset A", r1a, '0); chk("R8 reset B", r1b, '0);
    chk("R8 reset A", r2a, '0); chk("R8 reset B", r2b, '0);
    chk("R8 reset B", r3b, '0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // Stimulus table
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] w;
      w = VECS[v];
      step(w[31], w[30], w[29:24], w[23:16], w[15], w[14], w[13:8], w[7:0]);
    end

    // Random phase with forced address matches (R6, R7)
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] aa, ba;
      aa = AW'($urandom_range(0, DEPTH-1));
      ba = ($urandom_range(0, 3) == 0) ? aa : AW'($urandom_range(0, DEPTH-1));
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), aa, DW'($urandom),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), ba, DW'($urandom));
    end

    // Reset in mid-run: outputs clear at once, array clears (R8)
    @(negedge clk);
    a_en = 0; b_en = 0;
    #1.0;
    rst_n = 1'b0;
    #0.5;
    chk("R8 async clear A", r1a, '0);
    chk("R8 async clear B", r1b, '0);
    chk("R8 async clear A", r2a, '0);
    clear_models();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    step(1'b1, 1'b0, 6'd5,  8'h00, 1'b1, 1'b0, 6'd12, 8'h00);
    step(1'b1, 1'b0, 6'd20, 8'h00, 1'b1, 1'b1, 6'd7,  8'h99);
    // Split port B ignores write enable: word 7 still zero there (R9)
    step(1'b0, 1'b0, 6'd0,  8'h00, 1'b1, 1'b0, 6'd7,  8'h00);
    chk("R9 split port B write ignored", r3b, 8'h00);
    chk("R6 full port B write landed", r1b, 8'h99);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule